// File: doc/BRIEF.md
# Wake Request Watchdog Timer

This block guards the time between a remote wake request and the host's response. When the receive side reports a wake request, the block loads a host-chosen count and counts down by one per system clock. If the host clears the wake interrupt before the count runs out, the countdown is dropped silently. If the count runs out first, the block raises a single-cycle request that tells the frame transmitter to send a "host not responding" notification to the remote node.

The host programs the wait length through a simple write port and picks a value that matches its own wake-up latency. A wake-status bit shows whether a wake request is still waiting for the host. A count of zero turns the watchdog off. A parameter sets which event wins when a wake request and a host clear arrive in the same cycle.

Top module: `wake_wdog`

## Requirements
- R1: After reset, `wake_status_o` and `notify_req_o` are 0 and the reload count is 0.
- R2: A wake request sampled at clock edge k with a non-zero reload count N and no host clear makes `notify_req_o` high in the cycle after edge k+N, and low in every cycle from edge k to edge k+N.
- R3: A host clear sampled while the countdown runs cancels it. No `notify_req_o` pulse follows.
- R4: While the reload count is 0, wake requests start no countdown and never produce a `notify_req_o` pulse.
- R5: A wake request that arrives while a countdown runs reloads the count with N. The pulse then comes N edges after the second request.
- R6: `wake_status_o` goes to 1 at the edge after a wake request and to 0 at the edge after a host clear. It keeps its value across a timeout.
- R7: Each countdown that expires gives exactly one `notify_req_o` pulse, one cycle wide. The pulse does not repeat while no new wake request comes.
- R8: With the default priority (clear wins), a wake request and a host clear in the same cycle leave `wake_status_o` at 0 and start no countdown.
- R9: Writing a new reload count during a countdown does not change the countdown in progress. The new value applies from the next wake request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cnt_we_i | input | 1 | Write strobe for the reload count |
| cnt_wdata_i | input | CNT_W | Reload count value to write |
| wake_req_i | input | 1 | One-cycle wake request from the receive side |
| host_clr_i | input | 1 | Host clears the wake interrupt |
| wake_status_o | output | 1 | Wake request pending, readable by the host |
| notify_req_o | output | 1 | One-cycle request to send the not-responding frame |

## Verification
The hardest cases to reach are the ones where two events overlap in time: a second wake request or a reload-count write that lands in the middle of a running countdown, and a wake request and host clear that come in the same cycle. The directed tasks set these up by counting clock edges from the first wake request. They then place the second event at a known remaining count and predict the exact edge of the pulse, or confirm that no pulse comes in a window longer than the reload value.

// File: rtl/wake_wdog_pkg.sv
package wake_wdog_pkg;
   // Resolution when a wake request and a host clear coincide
   typedef enum logic {
      PRIO_WAKE  = 1'b0,
      PRIO_CLEAR = 1'b1
   } wdog_prio_e;

   localparam int unsigned WDOG_CNT_W_DEF = 16;
   localparam int unsigned WDOG_CNT_W_MAX = 32;
endpackage

// File: rtl/wdog_reload_reg.sv
module wdog_reload_reg #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             we_i,
   input  logic [CNT_W-1:0] wdata_i,
   output logic [CNT_W-1:0] value_o,
   output logic             enabled_o
);
   logic [CNT_W-1:0] value_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)   value_q <= '0;
      else if (we_i) value_q <= wdata_i;
   end

   assign value_o   = value_q;
   assign enabled_o = (value_q != '0);

   // R9: the stored count changes only on a write
   p_hold_no_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !we_i |=> value_q == $past(value_q));
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown
   import wake_wdog_pkg::*;
#(
   parameter int unsigned CNT_W = 16,
   parameter wdog_prio_e  PRIO  = PRIO_CLEAR
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wake_i,
   input  logic             clr_i,
   input  logic             enabled_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic             fire_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             load, cancel, expire, fire_q;

   generate
      if (PRIO == PRIO_CLEAR) begin : g_clear_wins
         assign cancel = clr_i;
         assign load   = wake_i && enabled_i && !clr_i;
      end else begin : g_wake_wins
         assign load   = wake_i && enabled_i;
         assign cancel = clr_i && !load;
      end
   endgenerate

   always_comb begin
      cnt_d = cnt_q;
      if (cancel)              cnt_d = '0;
      else if (load)           cnt_d = reload_i;
      else if (cnt_q != '0)    cnt_d = cnt_q - ONE;
   end

   assign expire = (cnt_q == ONE) && !cancel && !load;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         fire_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_d;
         fire_q <= expire;
      end
   end

   assign fire_o = fire_q;

   p_decrement_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q != '0 && !cancel && !load) |=> cnt_q == $past(cnt_q) - ONE);
   p_fire_from_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_q |-> $past(cnt_q) == ONE);
   p_clear_cancels_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !wake_i) |=> (cnt_q == '0 && !fire_q));
   p_zero_reload_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!enabled_i && cnt_q == '0) |=> cnt_q == '0);
   p_single_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_q |=> !fire_q);
endmodule

// File: rtl/wdog_status.sv
module wdog_status
   import wake_wdog_pkg::*;
#(
   parameter wdog_prio_e PRIO = PRIO_CLEAR
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic wake_i,
   input  logic clr_i,
   output logic status_o
);
   logic set, reset_bit, status_q;

   generate
      if (PRIO == PRIO_CLEAR) begin : g_clear_wins
         assign reset_bit = clr_i;
         assign set       = wake_i && !clr_i;
      end else begin : g_wake_wins
         assign set       = wake_i;
         assign reset_bit = clr_i && !wake_i;
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni)        status_q <= 1'b0;
      else if (reset_bit) status_q <= 1'b0;
      else if (set)       status_q <= 1'b1;
   end

   assign status_o = status_q;

   p_status_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wake_i && !clr_i) |=> status_q);
   p_status_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !wake_i) |=> !status_q);
   p_status_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && !wake_i) |=> status_q == $past(status_q));
endmodule

// File: rtl/wake_wdog.sv
module wake_wdog
   import wake_wdog_pkg::*;
#(
   parameter int unsigned CNT_W = WDOG_CNT_W_DEF,
   parameter wdog_prio_e  PRIO  = PRIO_CLEAR
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             cnt_we_i,
   input  logic [CNT_W-1:0] cnt_wdata_i,
   input  logic             wake_req_i,
   input  logic             host_clr_i,
   output logic             wake_status_o,
   output logic             notify_req_o
);
   initial begin : g_param_check
      if (CNT_W < 2 || CNT_W > WDOG_CNT_W_MAX)
         $fatal(1, "wake_wdog: CNT_W must lie in 2..%0d", WDOG_CNT_W_MAX);
   end

   logic [CNT_W-1:0] reload;
   logic             enabled;

   wdog_reload_reg #(.CNT_W(CNT_W)) u_reload (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (cnt_we_i),
      .wdata_i   (cnt_wdata_i),
      .value_o   (reload),
      .enabled_o (enabled)
   );

   wdog_countdown #(.CNT_W(CNT_W), .PRIO(PRIO)) u_count (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wake_i    (wake_req_i),
      .clr_i     (host_clr_i),
      .enabled_i (enabled),
      .reload_i  (reload),
      .fire_o    (notify_req_o)
   );

   wdog_status #(.PRIO(PRIO)) u_status (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wake_i   (wake_req_i),
      .clr_i    (host_clr_i),
      .status_o (wake_status_o)
   );

   // R1: outputs idle in the first cycle out of reset
   p_reset_idle_r1: assert property (@(posedge clk_i)
      !rst_ni |=> (!notify_req_o && !wake_status_o));
endmodule

// File: tb/wake_wdog_tb_top.sv
module wake_wdog_tb_top;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          we = 1'b0;
   logic [CW-1:0] wdata = '0;
   logic          wake = 1'b0;
   logic          clr = 1'b0;
   logic          status, notify;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   wake_wdog #(.CNT_W(CW)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .cnt_we_i(we), .cnt_wdata_i(wdata),
      .wake_req_i(wake), .host_clr_i(clr),
      .wake_status_o(status), .notify_req_o(notify)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic set_reload(input int v);
      we = 1'b1; wdata = CW'(v);
      step();
      we = 1'b0;
   endtask

   task automatic pulse_wake();
      wake = 1'b1;
      step();
      wake = 1'b0;
   endtask

   task automatic pulse_clr();
      clr = 1'b1;
      step();
      clr = 1'b0;
   endtask

   // after the wake edge already stepped: expect pulse exactly n edges later
   task automatic expect_pulse(input string req, input int n);
      for (int i = 1; i <= n; i++) begin
         step();
         chk(req, notify, (i == n));
      end
      for (int i = 0; i < 4; i++) begin
         step();
         chk("R7 no repeat", notify, 1'b0);
      end
   endtask

   task automatic expect_quiet(input string req, input int n);
      for (int i = 0; i < n; i++) begin
         step();
         chk(req, notify, 1'b0);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      step(); step();
      rst_n = 1'b1;
      chk("R1 status", status, 1'b0);
      chk("R1 notify", notify, 1'b0);
      pulse_wake();               // reload still zero after reset
      expect_quiet("R1 reload zero", 6);
      pulse_clr();
   endtask

   task automatic t_basic(input int n);
      set_reload(n);
      pulse_wake();
      chk("R6 status set", status, 1'b1);
      expect_pulse("R2 timeout", n);
      chk("R6 status kept", status, 1'b1);
      pulse_clr();
      chk("R6 status cleared", status, 1'b0);
   endtask

   task automatic t_cancel();
      set_reload(10);
      pulse_wake();
      step(); step(); step();
      pulse_clr();
      chk("R3 status", status, 1'b0);
      expect_quiet("R3 cancelled", 14);
   endtask

   task automatic t_zero();
      set_reload(0);
      pulse_wake();
      chk("R6 status zero reload", status, 1'b1);
      expect_quiet("R4 disabled", 12);
      pulse_clr();
   endtask

   task automatic t_rewake();
      set_reload(8);
      pulse_wake();
      step(); step(); step(); step();
      chk("R5 no early", notify, 1'b0);
      pulse_wake();
      expect_pulse("R5 reload", 8);
      pulse_clr();
   endtask

   task automatic t_same_cycle();
      set_reload(5);
      wake = 1'b1; clr = 1'b1;
      step();
      wake = 1'b0; clr = 1'b0;
      chk("R8 status", status, 1'b0);
      expect_quiet("R8 no arm", 9);
   endtask

   task automatic t_reload_change();
      set_reload(6);
      pulse_wake();
      set_reload(3);               // one edge used: 5 remain
      expect_pulse("R9 running unchanged", 5);
      pulse_wake();
      expect_pulse("R9 new value", 3);
      pulse_clr();
   endtask

   initial begin
      step();
      t_reset();
      t_basic(1);
      t_basic(5);
      t_basic(20);
      t_cancel();
      t_zero();
      t_rewake();
      t_same_cycle();
      t_reload_change();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule